// File: doc/BRIEF.md
# Erased-Sector Parity Filter

This block watches one flash sector go past as a byte stream, together with the nine parity bytes that belong to it, and deals with the special case of an erased sector. An erased sector reads as all ones. The error-correction arithmetic is done elsewhere. This filter only decides what to do with a blank sector.

On a write, the encoder's nine parity bytes follow the 512 data bytes. If those nine bytes are exactly the parity that an all-ones sector produces, the filter replaces them with nine 0xFF bytes. A blank page then stays blank in the spare area, and a later partial-page write into it is still possible. Any other parity passes through unchanged.

On a read, the stored parity arrives first and the 512 data bytes follow it. If every one of the 521 bytes is 0xFF, the filter raises its erased flag and withholds the decoder start. The sector then reports zero corrected errors without being decoded. Any other content produces a one-cycle decoder start pulse.

Top module: `blank_sector_filter`

## Requirements
- R1: While reset is active and after its release, with no sector yet streamed, `res_done`, `res_erased`, `dec_start` and `par_vld` are all low.
- R2: A byte is accepted only in a cycle with `in_vld` high. A byte accepted with `in_sos` high is byte 0 of a new sector, and `in_mode` is sampled in that same cycle (0 = read, 1 = write). In read mode the sector is 9 parity bytes followed by 512 data bytes. In write mode it is 512 data bytes followed by 9 parity bytes.
- R3: `res_done` rises in the cycle after the 521st byte of a sector is accepted. It then stays high until the clock edge that accepts the next byte carrying `in_sos`, and is low after that edge.
- R4: In read mode, `res_erased` is high while `res_done` is high if and only if all 521 accepted bytes of the sector equal 0xFF. A single other byte anywhere clears it, including parity byte 0, data byte 0, data byte 256 and data byte 511.
- R5: `dec_start` is a single-cycle pulse that coincides with the first cycle of `res_done`. It occurs only for a read-mode sector that is not erased. It never occurs for an erased sector or a write-mode sector.
- R6: In write mode, `par_out` presents the 9 captured parity bytes, with parity byte k at bits [8k+7:8k]. If they equal, in stream order, CD 9D 90 58 F4 8B FF B7 6F, then `par_out` is all ones instead. `par_vld` is high exactly while `res_done` is high for a write-mode sector.
- R7: A byte with `in_sos` arriving in the middle of a sector discards everything accepted so far and starts a new sector, in the newly sampled mode.
- R8: Once a sector is complete, bytes presented with `in_vld` high but without `in_sos` are ignored: `res_done`, `res_erased` and `par_out` keep their values. Cycles with `in_vld` low do not advance the byte count.
- R9: `res_erased` is low in write mode. Both `res_erased` and `par_vld` are low whenever `res_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Byte strobe |
| in_sos | input | 1 | Marks the strobed byte as byte 0 of a sector |
| in_mode | input | 1 | Direction, sampled with `in_sos`: 0 read, 1 write |
| in_byte | input | 8 | Stream byte |
| res_done | output | 1 | Sector complete; results valid |
| res_erased | output | 1 | Read sector is entirely 0xFF; decoder is bypassed |
| dec_start | output | 1 | One-cycle pulse that starts the decoder for a non-blank read sector |
| par_vld | output | 1 | `par_out` is valid (write sector complete) |
| par_out | output | 72 | Final parity, byte k at bits [8k+7:8k] |

## Verification
The hardest situation to reach from the ports is a write sector whose parity matches the blank pattern in eight of its nine bytes. Random parity almost never comes close to the blank pattern. The stimulus therefore plants the exact pattern and then corrupts only the first or only the last parity byte, which shows that the comparison covers all nine bytes and not just a prefix. The read side has a similar problem: a random sector is almost never blank. Sectors are therefore built all-ones with a single non-FF byte placed at the positions named in R4 or at a random position. Random idle gaps and restarts in mid-sector are mixed into these cases.

// File: rtl/blank_filter_pkg.sv
package blank_filter_pkg;
   typedef enum logic {
      MODE_READ  = 1'b0,
      MODE_WRITE = 1'b1
   } sec_mode_e;

   function automatic logic byte_is_ones(input logic [7:0] b);
      return b == 8'hFF;
   endfunction
endpackage

// File: rtl/bsf_tracker.sv
module bsf_tracker
   import blank_filter_pkg::*;
#(
   parameter int DATA_BYTES = 512,
   parameter int PAR_BYTES  = 9,
   localparam int TOTAL     = DATA_BYTES + PAR_BYTES,
   localparam int CNT_W     = $clog2(TOTAL + 1),
   localparam int SLOT_W    = (PAR_BYTES > 1) ? $clog2(PAR_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld,
   input  logic              sos,
   input  logic              mode,
   output logic              take,
   output logic              first,
   output logic              last,
   output logic              par_hit,
   output logic [SLOT_W-1:0] par_slot,
   output sec_mode_e         mode_q,
   output sec_mode_e         cur_mode,
   output logic              done
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] idx;
   logic [CNT_W-1:0] woff;
   logic             active;

   assign first    = vld & sos;
   assign take     = vld & (sos | active);
   assign idx      = sos ? '0 : cnt;
   assign cur_mode = sos ? sec_mode_e'(mode) : mode_q;
   assign last     = take & (idx == CNT_W'(TOTAL - 1));
   assign woff     = idx - CNT_W'(DATA_BYTES);

   always_comb begin
      if (cur_mode == MODE_READ) begin
         par_hit  = take & (idx < CNT_W'(PAR_BYTES));
         par_slot = idx[SLOT_W-1:0];
      end else begin
         par_hit  = take & (idx >= CNT_W'(DATA_BYTES));
         par_slot = woff[SLOT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
         done   <= 1'b0;
         mode_q <= MODE_READ;
      end else if (first) begin
         cnt    <= CNT_W'(1);
         active <= 1'b1;
         done   <= 1'b0;
         mode_q <= sec_mode_e'(mode);
      end else if (take) begin
         cnt <= cnt + CNT_W'(1);
         if (last) begin
            active <= 1'b0;
            done   <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/bsf_blank_acc.sv
module bsf_blank_acc
   import blank_filter_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic       first,
   input  logic [7:0] din,
   output logic       all_ff_d,
   output logic       all_ff_q
);
   always_comb begin
      all_ff_d = all_ff_q;
      if (take)
         all_ff_d = byte_is_ones(din) & (first | all_ff_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) all_ff_q <= 1'b0;
      else        all_ff_q <= all_ff_d;
   end
endmodule

// File: rtl/bsf_par_store.sv
module bsf_par_store #(
   parameter int                        PAR_BYTES = 9,
   parameter logic [PAR_BYTES*8-1:0]    BLANK_PAR = 72'h6FB7FF8BF458909DCD,
   parameter bit                        SUBST_EN  = 1'b1,
   localparam int                       SLOT_W    = (PAR_BYTES > 1) ? $clog2(PAR_BYTES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic [SLOT_W-1:0]      slot,
   input  logic [7:0]             din,
   output logic [PAR_BYTES*8-1:0] par_out
);
   logic [PAR_BYTES*8-1:0] held;
   logic [PAR_BYTES-1:0]   eq;

   for (genvar k = 0; k < PAR_BYTES; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            held[8*k +: 8] <= '0;
         else if (wr && slot == SLOT_W'(k))
            held[8*k +: 8] <= din;
      end
      assign eq[k] = held[8*k +: 8] == BLANK_PAR[8*k +: 8];
   end

   if (SUBST_EN) begin : g_subst
      assign par_out = (&eq) ? '1 : held;
   end else begin : g_pass
      assign par_out = held;
   end
endmodule

// File: rtl/blank_sector_filter.sv
module blank_sector_filter
   import blank_filter_pkg::*;
#(
   parameter int                     DATA_BYTES = 512,
   parameter int                     PAR_BYTES  = 9,
   parameter logic [PAR_BYTES*8-1:0] BLANK_PAR  = 72'h6FB7FF8BF458909DCD,
   parameter bit                     SUBST_EN   = 1'b1,
   localparam int                    PAR_W      = PAR_BYTES * 8,
   localparam int                    SLOT_W     = (PAR_BYTES > 1) ? $clog2(PAR_BYTES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic             in_sos,
   input  logic             in_mode,
   input  logic [7:0]       in_byte,
   output logic             res_done,
   output logic             res_erased,
   output logic             dec_start,
   output logic             par_vld,
   output logic [PAR_W-1:0] par_out
);
   if (PAR_BYTES < 1 || DATA_BYTES < 2) begin : g_bad_cfg
      $error("blank_sector_filter: PAR_BYTES must be >= 1 and DATA_BYTES >= 2");
   end

   logic              take, first, last, par_hit;
   logic [SLOT_W-1:0] par_slot;
   sec_mode_e         mode_q, cur_mode;
   logic              all_ff_d, all_ff_q;
   logic              start_q;

   bsf_tracker #(.DATA_BYTES(DATA_BYTES), .PAR_BYTES(PAR_BYTES)) u_track (
      .clk(clk), .rst_n(rst_n), .vld(in_vld), .sos(in_sos), .mode(in_mode),
      .take(take), .first(first), .last(last), .par_hit(par_hit),
      .par_slot(par_slot), .mode_q(mode_q), .cur_mode(cur_mode), .done(res_done)
   );

   bsf_blank_acc u_acc (
      .clk(clk), .rst_n(rst_n), .take(take), .first(first), .din(in_byte),
      .all_ff_d(all_ff_d), .all_ff_q(all_ff_q)
   );

   bsf_par_store #(.PAR_BYTES(PAR_BYTES), .BLANK_PAR(BLANK_PAR), .SUBST_EN(SUBST_EN)) u_par (
      .clk(clk), .rst_n(rst_n), .wr(par_hit), .slot(par_slot), .din(in_byte),
      .par_out(par_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_q <= 1'b0;
      else        start_q <= last & (cur_mode == MODE_READ) & ~all_ff_d;
   end

   assign dec_start  = start_q;
   assign res_erased = res_done & (mode_q == MODE_READ) & all_ff_q;
   assign par_vld    = res_done & (mode_q == MODE_WRITE);
endmodule

// File: rtl/blank_sector_filter_chk.sv
module blank_sector_filter_chk #(
   parameter int PAR_W = 72
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_vld,
   input logic             in_sos,
   input logic             res_done,
   input logic             res_erased,
   input logic             dec_start,
   input logic             par_vld,
   input logic [PAR_W-1:0] par_out
);
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !res_done |-> (!res_erased && !par_vld));

   a_r9_mode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_erased && par_vld));

   a_r5_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      dec_start |-> (res_done && !res_erased && !par_vld));

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dec_start |=> !dec_start);

   a_r5_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      dec_start |-> $rose(res_done));

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && !(in_vld && in_sos)) |=> res_done);

   a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_sos) |=> !res_done);

   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && !(in_vld && in_sos)) |=> ($stable(res_erased) && $stable(par_out)));
endmodule

bind blank_sector_filter blank_sector_filter_chk #(.PAR_W(PAR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sos(in_sos),
   .res_done(res_done), .res_erased(res_erased), .dec_start(dec_start),
   .par_vld(par_vld), .par_out(par_out)
);

// File: tb/blank_sector_filter_bench.sv
module blank_sector_filter_bench;
   localparam int DB    = 512;
   localparam int PB    = 9;
   localparam int TOT   = DB + PB;
   localparam logic [71:0] BLANK = 72'h6FB7FF8BF458909DCD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0, in_sos = 1'b0, in_mode = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        res_done, res_erased, dec_start, par_vld;
   logic [71:0] par_out;

   int checks = 0;
   int errors = 0;
   logic [7:0] s [TOT];

   always #2.5 clk = ~clk;

   blank_sector_filter u_blank_sector_filter (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sos(in_sos),
      .in_mode(in_mode), .in_byte(in_byte), .res_done(res_done),
      .res_erased(res_erased), .dec_start(dec_start), .par_vld(par_vld),
      .par_out(par_out)
   );

   task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit exp_blank();
      for (int i = 0; i < TOT; i++)
         if (s[i] != 8'hFF) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [71:0] exp_par();
      logic [71:0] p;
      for (int k = 0; k < PB; k++) p[8*k +: 8] = s[DB + k];
      return (p == BLANK) ? '1 : p;
   endfunction

   task automatic fill_ones();
      for (int i = 0; i < TOT; i++) s[i] = 8'hFF;
   endtask

   task automatic fill_random();
      for (int i = 0; i < TOT; i++) s[i] = 8'($urandom);
   endtask

   task automatic plant_blank_par();
      for (int k = 0; k < PB; k++) s[DB + k] = BLANK[8*k +: 8];
   endtask

   // streams s[] (or its first n bytes); returns at the negedge after the last accepted byte
   task automatic stream(input bit mode, input int n, input int maxgap);
      for (int i = 0; i < n; i++) begin
         if (maxgap > 0) begin
            int g = int'($urandom_range(maxgap, 0));
            repeat (g) begin
               in_vld = 1'b0; in_sos = 1'b0; in_byte = 8'h00;
               @(negedge clk);
            end
         end
         in_vld = 1'b1; in_sos = (i == 0); in_mode = mode; in_byte = s[i];
         @(negedge clk);
      end
      in_vld = 1'b0; in_sos = 1'b0;
   endtask

   task automatic run_read(input string tag, input int maxgap);
      bit e = exp_blank();
      stream(1'b0, TOT, maxgap);
      check({tag, " R3 done"}, 72'(res_done), 72'd1);
      check({tag, " R4 erased"}, 72'(res_erased), 72'(e));
      check({tag, " R5 start"}, 72'(dec_start), 72'(!e));
      check({tag, " R9 par_vld"}, 72'(par_vld), 72'd0);
      @(negedge clk);
      check({tag, " R5 pulse end"}, 72'(dec_start), 72'd0);
      check({tag, " R3 hold"}, 72'(res_done), 72'd1);
   endtask

   task automatic run_write(input string tag, input int maxgap);
      logic [71:0] ep = exp_par();
      stream(1'b1, TOT, maxgap);
      check({tag, " R3 done"}, 72'(res_done), 72'd1);
      check({tag, " R6 par_vld"}, 72'(par_vld), 72'd1);
      check({tag, " R6 par_out"}, par_out, ep);
      check({tag, " R9 no erased"}, 72'(res_erased), 72'd0);
      check({tag, " R5 no start"}, 72'(dec_start), 72'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 done in reset", 72'(res_done), 72'd0);
      rst_n = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R1 done", 72'(res_done), 72'd0);
      check("R1 erased", 72'(res_erased), 72'd0);
      check("R1 dec_start", 72'(dec_start), 72'd0);
      check("R1 par_vld", 72'(par_vld), 72'd0);

      // R4 blank read, with and without gaps
      fill_ones(); run_read("blank read", 0);
      fill_ones(); run_read("blank read gaps R8", 3);

      // R8: extra bytes after completion without sos are ignored
      for (int i = 0; i < 20; i++) begin
         in_vld = 1'b1; in_sos = 1'b0; in_byte = 8'h00; @(negedge clk);
      end
      in_vld = 1'b0;
      check("R8 done kept", 72'(res_done), 72'd1);
      check("R8 erased kept", 72'(res_erased), 72'd1);

      // R4 single defects at the probe positions (read order: parity first)
      fill_ones(); s[0] = 8'h00;            run_read("read par0", 0);
      fill_ones(); s[PB] = 8'hFE;           run_read("read data0", 1);
      fill_ones(); s[PB + 256] = 8'h7F;     run_read("read mid", 0);
      fill_ones(); s[TOT - 1] = 8'hEF;      run_read("read last", 2);
      fill_ones(); s[PB - 1] = 8'hFD;       run_read("read par8", 0);

      // R6 blank parity substituted, and near misses pass through
      fill_random(); plant_blank_par(); run_write("write blank par", 1);
      fill_ones();   plant_blank_par(); run_write("write ones sector", 0);
      fill_random(); plant_blank_par(); s[DB] = 8'hCC;      run_write("write miss byte0", 0);
      fill_random(); plant_blank_par(); s[TOT - 1] = 8'h6E; run_write("write miss byte8", 2);
      // R2: in write mode the first 512 bytes are data and do not feed par_out
      fill_ones(); plant_blank_par(); for (int i = 0; i < 9; i++) s[i] = BLANK[8*i +: 8];
      s[DB + 4] = 8'h00; run_write("write order R2", 0);

      // R7 restart in mid sector: partial write, then full blank read
      fill_random(); stream(1'b1, 100, 0);
      check("R7 not done mid", 72'(res_done), 72'd0);
      fill_ones(); run_read("restart R7", 0);
      // R3 clear on new sos
      in_vld = 1'b1; in_sos = 1'b1; in_mode = 1'b0; in_byte = 8'hFF;
      @(negedge clk);
      in_vld = 1'b0; in_sos = 1'b0;
      check("R3 cleared by sos", 72'(res_done), 72'd0);
      check("R9 erased low", 72'(res_erased), 72'd0);
      fill_random(); stream(1'b0, 300, 0);
      fill_ones(); run_read("restart read R7", 1);

      // random mix
      for (int t = 0; t < 14; t++) begin
         if ($urandom_range(1, 0) == 1) begin
            fill_random();
            if ($urandom_range(2, 0) == 0) plant_blank_par();
            run_write("rand write R6", int'($urandom_range(1, 0)));
         end else begin
            fill_ones();
            if ($urandom_range(2, 0) != 0) s[$urandom_range(TOT - 1, 0)] = 8'($urandom_range(254, 0));
            run_read("rand read R4", int'($urandom_range(1, 0)));
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule